// File: doc/BRIEF.md
# Set-Associative Read Cache with Least-Recently-Used Replacement

This block is a read-only cache that keeps multi-word lines in several parallel ways. A word address is split into a tag, a set index and a word offset. Every way holds its own valid bits, tags and line data, and compares its stored tag at the indexed set at the same time as the other ways. Within each way a multiplexer picks the addressed word. A second multiplexer then picks the output of the way that hit. A hit returns the word one cycle after the request is accepted.

On a miss the cache stops accepting requests. It chooses a way to overwrite: the lowest-numbered invalid way in the set if one exists, and otherwise the least recently used way. It then reads the whole line from the next memory level, one word per beat, starting at word 0. When the last word arrives it records the new tag and marks the line valid. In the following cycle it returns the requested word, flagged as a miss. A single-line invalidation command lets the line that holds an address be discarded.

Geometry is set by parameters: the number of ways, the index width and the word-offset width. The default is 2 ways, 8 sets and 4-word lines, with 32-bit data and 30-bit word addresses.

Top module: `sa_cache`

## Requirements
- R1: `addr_i` is a word address. Bits [OFS_W-1:0] select the word within the line, bits [OFS_W+IDX_W-1:OFS_W] select the set, and the remaining upper bits are the tag. The returned word is the memory word at exactly that address.
- R2: When a request is accepted (`req_i`=1, `inv_i`=0, `ready_o`=1) and its line is resident, `rsp_valid_o`=1 and `rsp_hit_o`=1 in the next cycle, with the addressed word on `rsp_data_o`.
- R3: When an accepted request misses, `ready_o` is 0 and `mem_req_o` is 1 from the next cycle until the refill ends. The refill reads the 2^OFS_W words of the line in ascending order from word 0. `mem_addr_o` is {tag, index, beat number}, and each word is taken in a cycle where `mem_valid_i`=1.
- R4: One cycle after the last refill word is taken, `rsp_valid_o`=1 and `rsp_hit_o`=0 with the requested word, and `ready_o` is 1 again in that cycle.
- R5: At no time does more than one way report a tag match.
- R6: On a miss, if any way of the set is invalid, the lowest-numbered invalid way is filled, even when it is the most recently used way.
- R7: When all ways of the set are valid, the least recently used way is replaced. Use is updated by every hit and every refill.
- R8: `inv_i`=1 while `ready_o`=1 clears the valid bit of the line matching `addr_i`, if one is resident, and produces no response. `req_i` is ignored in that cycle. A later read of that address misses.
- R9: After reset `ready_o`=1, `rsp_valid_o`=0 and `mem_req_o`=0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request |
| inv_i | input | 1 | Invalidate the line holding `addr_i` |
| addr_i | input | WADDR_W | Word address for read or invalidate |
| ready_o | output | 1 | Cache can accept a command |
| rsp_valid_o | output | 1 | Response word valid |
| rsp_hit_o | output | 1 | Response came from a hit (1) or a refill (0) |
| rsp_data_o | output | DATA_W | Response word |
| mem_req_o | output | 1 | Refill in progress, memory read requested |
| mem_addr_o | output | WADDR_W | Word address of the current refill beat |
| mem_valid_i | input | 1 | Refill word valid |
| mem_rdata_i | input | DATA_W | Refill word |

## Verification
A corrupted tag, valid bit or age state shows up at the ports at the next access to the affected set. A line that should be resident shows up as a miss: `ready_o` falls one cycle after the request and memory beats appear. A line that should be gone shows up as an unexpected hit one cycle after the request. The bench provokes these by building a known age order in one set and then evicting, re-reading and invalidating lines. Every response's hit flag and word are compared against a memory model. A wrong word offset or refill order shows up as a bad word, or as a wrong `mem_addr_o` on the first beat that strays.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} state_e;
endpackage

// File: rtl/sa_cache_way.sv
module sa_cache_way #(
  parameter int IDX_W  = 3,
  parameter int OFS_W  = 2,
  parameter int TAG_W  = 25,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [OFS_W-1:0]  rd_ofs_i,
  input  logic              inv_i,
  input  logic              we_i,
  input  logic              commit_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [OFS_W-1:0]  wr_ofs_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WORDS = 1 << OFS_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS*WORDS];

  assign valid_o = valid_q[rd_idx_i];
  assign hit_o   = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign word_o  = data_q[{rd_idx_i, rd_ofs_i}];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (commit_i) valid_q[wr_idx_i] <= 1'b1;
    else if (inv_i && hit_o) valid_q[rd_idx_i] <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) data_q[{wr_idx_i, wr_ofs_i}] <= wr_data_i;
    if (commit_i) tag_q[wr_idx_i] <= wr_tag_i;
  end
endmodule

// File: rtl/sa_cache_lru.sv
module sa_cache_lru #(
  parameter int WAYS  = 2,
  parameter int IDX_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    touch_i,
  input  logic [IDX_W-1:0]        touch_idx_i,
  input  logic [$clog2(WAYS)-1:0] touch_way_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  output logic [$clog2(WAYS)-1:0] victim_o
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  // age 0 = most recent, WAYS-1 = least recent; ages form a permutation per set
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx_i][touch_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i) age_q[touch_idx_i][w] <= '0;
        else if (age_q[touch_idx_i][w] < touched_age)
          age_q[touch_idx_i][w] <= age_q[touch_idx_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[rd_idx_i][w] == {WAY_W{1'b1}}) victim_o = WAY_W'(w);
  end
endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int WAYS    = 2,
  parameter int IDX_W   = 3,
  parameter int OFS_W   = 2,
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               inv_i,
  input  logic [WADDR_W-1:0] addr_i,
  output logic               ready_o,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [DATA_W-1:0]  rsp_data_o,
  output logic               mem_req_o,
  output logic [WADDR_W-1:0] mem_addr_o,
  input  logic               mem_valid_i,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  localparam int TAG_W = WADDR_W - IDX_W - OFS_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [OFS_W-1:0] req_ofs;
  assign req_tag = addr_i[WADDR_W-1 -: TAG_W];
  assign req_idx = addr_i[OFS_W +: IDX_W];
  assign req_ofs = addr_i[OFS_W-1:0];

  state_e           state_q;
  logic [TAG_W-1:0] miss_tag_q;
  logic [IDX_W-1:0] miss_idx_q;
  logic [OFS_W-1:0] miss_ofs_q, fill_cnt_q;
  logic [WAY_W-1:0] victim_q;
  logic [DATA_W-1:0] cap_q;

  logic [WAYS-1:0]   way_hit, way_valid;
  logic [DATA_W-1:0] way_word [WAYS];
  logic              hit, accept, do_inv, fill_we, fill_last, any_free, touch;
  logic [DATA_W-1:0] hit_word;
  logic [WAY_W-1:0]  hit_way, free_way, lru_victim, touch_way;
  logic [IDX_W-1:0]  touch_idx;

  assign ready_o   = (state_q == ST_IDLE);
  assign accept    = ready_o && req_i && !inv_i;
  assign do_inv    = ready_o && inv_i;
  assign fill_we   = (state_q == ST_FILL) && mem_valid_i;
  assign fill_last = fill_we && (fill_cnt_q == {OFS_W{1'b1}});
  assign mem_req_o = (state_q == ST_FILL);
  assign mem_addr_o = {miss_tag_q, miss_idx_q, fill_cnt_q};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    sa_cache_way #(
      .IDX_W(IDX_W), .OFS_W(OFS_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) i_way (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_idx_i (req_idx),
      .rd_tag_i (req_tag),
      .rd_ofs_i (req_ofs),
      .inv_i    (do_inv),
      .we_i     (fill_we && (victim_q == WAY_W'(w))),
      .commit_i (fill_last && (victim_q == WAY_W'(w))),
      .wr_idx_i (miss_idx_q),
      .wr_ofs_i (fill_cnt_q),
      .wr_tag_i (miss_tag_q),
      .wr_data_i(mem_rdata_i),
      .hit_o    (way_hit[w]),
      .valid_o  (way_valid[w]),
      .word_o   (way_word[w])
    );
  end

  // second-level mux: AND-OR over one-hot way hits
  always_comb begin
    hit_word = '0;
    hit_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_word = hit_word | (way_word[w] & {DATA_W{way_hit[w]}});
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit = |way_hit;

  always_comb begin
    free_way = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (!way_valid[w]) free_way = WAY_W'(w);
  end
  assign any_free = !(&way_valid);

  assign touch     = (accept && hit) || fill_last;
  assign touch_idx = fill_last ? miss_idx_q : req_idx;
  assign touch_way = fill_last ? victim_q : hit_way;

  sa_cache_lru #(.WAYS(WAYS), .IDX_W(IDX_W)) i_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (touch),
    .touch_idx_i(touch_idx),
    .touch_way_i(touch_way),
    .rd_idx_i   (req_idx),
    .victim_o   (lru_victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      miss_tag_q  <= '0;
      miss_idx_q  <= '0;
      miss_ofs_q  <= '0;
      fill_cnt_q  <= '0;
      victim_q    <= '0;
      cap_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && hit) begin
            rsp_valid_o <= 1'b1;
            rsp_hit_o   <= 1'b1;
            rsp_data_o  <= hit_word;
          end else if (accept) begin
            state_q    <= ST_FILL;
            miss_tag_q <= req_tag;
            miss_idx_q <= req_idx;
            miss_ofs_q <= req_ofs;
            fill_cnt_q <= '0;
            victim_q   <= any_free ? free_way : lru_victim;
          end
        end
        ST_FILL: begin
          if (fill_we) begin
            if (fill_cnt_q == miss_ofs_q) cap_q <= mem_rdata_i;
            fill_cnt_q <= fill_cnt_q + 1'b1;
            if (fill_last) begin
              state_q     <= ST_IDLE;
              rsp_valid_o <= 1'b1;
              rsp_hit_o   <= 1'b0;
              rsp_data_o  <= (fill_cnt_q == miss_ofs_q) ? mem_rdata_i : cap_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
  parameter int WAYS = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            inv_i,
  input logic            ready_o,
  input logic            rsp_valid_o,
  input logic            rsp_hit_o,
  input logic            mem_req_o,
  input logic            mem_valid_i,
  input logic [WAYS-1:0] way_hit_i
);
  AST_ONE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(way_hit_i)); // R5
  AST_HIT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !inv_i && ready_o && |way_hit_i) |=> (rsp_valid_o && rsp_hit_o)); // R2
  AST_MISS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !inv_i && ready_o && !(|way_hit_i)) |=> (!ready_o && mem_req_o)); // R3
  AST_FILL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o); // R3
  AST_MISS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> ($past(mem_req_o && mem_valid_i) && ready_o)); // R4
  AST_INV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && ready_o) |=> !rsp_valid_o); // R8
endmodule

bind sa_cache sa_cache_chk #(.WAYS(WAYS)) i_sa_cache_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .inv_i      (inv_i),
  .ready_o    (ready_o),
  .rsp_valid_o(rsp_valid_o),
  .rsp_hit_o  (rsp_hit_o),
  .mem_req_o  (mem_req_o),
  .mem_valid_i(mem_valid_i),
  .way_hit_i  (way_hit)
);

// File: tb/test_sa_cache.sv
`timescale 1ns/1ps
module test_sa_cache;
  localparam int WAYS = 2, IDX_W = 3, OFS_W = 2, WADDR_W = 30, DATA_W = 32;
  localparam int TAG_W = WADDR_W - IDX_W - OFS_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_i = 1'b0, inv_i = 1'b0, mem_valid_i = 1'b0;
  logic [WADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0]  mem_rdata_i = '0;
  logic ready_o, rsp_valid_o, rsp_hit_o, mem_req_o;
  logic [DATA_W-1:0]  rsp_data_o;
  logic [WADDR_W-1:0] mem_addr_o;

  always #2.5 clk = ~clk;

  sa_cache #(.WAYS(WAYS), .IDX_W(IDX_W), .OFS_W(OFS_W), .WADDR_W(WADDR_W), .DATA_W(DATA_W))
  i_sa_cache (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .inv_i(inv_i), .addr_i(addr_i),
    .ready_o(ready_o), .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o),
    .rsp_data_o(rsp_data_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i)
  );

  typedef struct {logic hit; logic [DATA_W-1:0] data; string rq;} exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0, beat = 0;
  logic [WADDR_W-1:0] miss_base = '0;

  function automatic logic [DATA_W-1:0] mem_word(logic [WADDR_W-1:0] a);
    return {2'b01, a} ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic [WADDR_W-1:0] mk(int tag, int idx, int ofs);
    return {TAG_W'(tag), IDX_W'(idx), OFS_W'(ofs)};
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // driver: issue one read, push expected, wait for it to be consumed
  task automatic rd(logic [WADDR_W-1:0] a, bit exp_hit, string rq);
    exp_t e;
    while (!ready_o) @(negedge clk);
    e.hit = exp_hit; e.data = mem_word(a); e.rq = rq;
    exp_q.push_back(e);
    miss_base = a; beat = 0;
    req_i = 1'b1; addr_i = a;
    @(negedge clk);
    req_i = 1'b0;
    if (!exp_hit) chk(!ready_o && mem_req_o, "R3", "stall after miss",
                      {30'd0, ready_o, mem_req_o}, 32'd1);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic inv(logic [WADDR_W-1:0] a, bit with_req);
    while (!ready_o) @(negedge clk);
    inv_i = 1'b1; req_i = with_req; addr_i = a;
    @(negedge clk);
    inv_i = 1'b0; req_i = 1'b0;
    chk(!rsp_valid_o && ready_o, "R8", "invalidate quiet",
        {30'd0, rsp_valid_o, ready_o}, 32'd1);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected response", rsp_data_o, '0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_hit_o == e.hit, e.rq, "hit flag", {31'd0, rsp_hit_o}, {31'd0, e.hit});
        chk(rsp_data_o == e.data, "R1", "data word", rsp_data_o, e.data);
      end
    end
  end

  // memory model: one word every other cycle, address order checked
  always @(negedge clk) begin
    if (mem_req_o && !mem_valid_i) begin
      chk(mem_addr_o == {miss_base[WADDR_W-1:OFS_W], OFS_W'(beat)}, "R3", "refill address",
          {2'b00, mem_addr_o}, {2'b00, miss_base[WADDR_W-1:OFS_W], OFS_W'(beat)});
      mem_rdata_i = mem_word(mem_addr_o);
      mem_valid_i = 1'b1;
      beat++;
    end else begin
      mem_valid_i = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready_o && !rsp_valid_o && !mem_req_o, "R9", "reset outputs",
        {29'd0, ready_o, rsp_valid_o, mem_req_o}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_o && !rsp_valid_o && !mem_req_o, "R9", "idle after reset",
        {29'd0, ready_o, rsp_valid_o, mem_req_o}, 32'd4);

    rd(mk(1, 0, 2), 1'b0, "R9");  // all lines invalid after reset
    rd(mk(1, 0, 1), 1'b1, "R2");
    rd(mk(1, 0, 3), 1'b1, "R2");
    rd(mk(2, 0, 3), 1'b0, "R4");  // fills invalid way 1
    rd(mk(1, 0, 0), 1'b1, "R6");  // both tags resident
    rd(mk(2, 0, 0), 1'b1, "R6");  // way of tag 1 now least recent
    rd(mk(3, 0, 1), 1'b0, "R7");  // evicts tag 1
    rd(mk(2, 0, 2), 1'b1, "R7");
    rd(mk(1, 0, 3), 1'b0, "R7");  // evicts tag 3
    rd(mk(3, 0, 0), 1'b0, "R7");  // evicts tag 2
    rd(mk(1, 0, 1), 1'b1, "R7");
    rd(mk(3, 0, 2), 1'b1, "R7");
    rd(mk(1, 0, 2), 1'b1, "R7");  // tag 1 most recent, tag 3 least
    inv(mk(1, 0, 0), 1'b0);
    rd(mk(4, 0, 1), 1'b0, "R6");  // invalid way preferred over LRU
    rd(mk(3, 0, 3), 1'b1, "R6");  // tag 3 survived
    rd(mk(1, 0, 0), 1'b0, "R8");  // invalidated line misses
    rd(mk(9, 5, 3), 1'b0, "R1");  // other set independent
    rd(mk(9, 5, 0), 1'b1, "R1");
    rd(mk(9, 6, 0), 1'b0, "R1");
    inv(mk(9, 5, 1), 1'b1);       // invalidation wins over read
    rd(mk(9, 5, 2), 1'b0, "R8");
    inv(mk(7, 6, 0), 1'b0);       // no resident match: line kept
    rd(mk(9, 6, 3), 1'b1, "R8");
    rd(mk(0, 7, 0), 1'b0, "R3");
    rd({TAG_W'('1), IDX_W'('1), OFS_W'('1)}, 1'b0, "R3");
    rd({TAG_W'('1), IDX_W'('1), OFS_W'(0)}, 1'b1, "R1");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule